// File: doc/BRIEF.md
# Maskable Interrupt and Input-Change Unit

This block gathers the interrupting conditions of a two-channel serial controller and its counter into one status word, gates that word with a software-written mask, and drives one active-low interrupt request. Seven of the conditions arrive as one-cycle set pulses from the channels and the counter. Each is removed only by the side effect that services it: a read of received data, a write of transmit data, a break-reset command or a stop-counter command. Writing the status word has no effect on it.

The eighth condition comes from four general-purpose input pins. Each pin passes through a synchroniser and is compared with its previous synchronised sample. A difference sets a per-pin change flag that stays set until the change register is read. The change register also returns the present synchronised level of each pin. If a new change arrives in the same cycle as the clearing read, that change is kept.

All strobes are single-cycle control pins sampled on the rising clock edge. There is no streaming data path, so no valid/ready handshake is used.

Top module: `intr_change_unit`

## Requirements
- R1: After reset, the status word, the mask, the latched change bits and the synchroniser stages are all zero, and `irq_n` is high.
- R2: Status bits 6..0 map as follows: bit0 transmit-ready A, bit1 receive-ready A, bit2 break-change A, bit3 counter-ready, bit4 transmit-ready B, bit5 receive-ready B, bit6 break-change B. A pulse on `cond_set[i]` sets bit i one cycle later. The bit holds until a pulse on `cond_clr[i]`, which is the service strobe for that condition (transmit-data write, receive-data read, break-reset command, stop-counter command), clears it one cycle later.
- R3: If `cond_set[i]` and `cond_clr[i]` are both high in one cycle, bit i is set afterwards.
- R4: `mask_wr` loads `mask_wdata` into the mask, and the new value is visible on `mask_rdata` one cycle later. `irq_n` is low exactly when some bit of `status` ANDed with the mask is one.
- R5: A mask write that clears the mask bit of every active condition drives `irq_n` high in the cycle after the write.
- R6: `chg_rdata[7:4]` reports the synchronised level of pins 3..0, two rising edges after the pin changes.
- R7: A change on pin i sets `chg_rdata[i]` three rising edges after the pin changes. Status bit7 is the OR of `chg_rdata[3:0]`.
- R8: A `chg_rd` pulse clears `chg_rdata[3:0]`, and with them status bit7, one cycle later. The level bits are not affected.
- R9: A pin change detected in the same cycle as a `chg_rd` pulse remains latched after that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_set | input | 7 | One-cycle set pulses for status bits 6..0 |
| cond_clr | input | 7 | One-cycle service strobes clearing status bits 6..0 |
| pins_in | input | 4 | Asynchronous general-purpose input pins |
| chg_rd | input | 1 | Change-register read strobe (clears latched change bits) |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | Mask write data |
| mask_rdata | output | 8 | Current mask |
| status | output | 8 | Status word; bit7 is the input-change condition |
| chg_rdata | output | 8 | {pin levels[3:0], latched change bits[3:0]} |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A status bit that is stuck, lost or left set shows on `status` one cycle after the set or clear pulse. Once the bit's mask bit is open, it also shows on `irq_n` in that same cycle. A wrong synchroniser depth moves the level bits away from the second edge and the change bits away from the third edge. A read-clear that gives priority to the clear drops the coincident change, so `chg_rdata[3:0]` and `irq_n` differ from the expected values one cycle after the read.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int unsigned SRC_COUNT  = 7;
  localparam int unsigned PIN_COUNT  = 4;
  localparam int unsigned SYNC_DEPTH = 2;
  localparam int unsigned STAT_W     = SRC_COUNT + 1;
endpackage

// File: rtl/pin_change_det.sv
module pin_change_det #(
  parameter int unsigned PINS  = 4,
  parameter int unsigned DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_raw,
  output logic [PINS-1:0] pin_level,
  output logic [PINS-1:0] pin_edge
);
  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic [DEPTH-1:0] stage_q;
    logic             prev_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        stage_q <= {stage_q[DEPTH-2:0], pin_raw[p]};
        prev_q  <= stage_q[DEPTH-1];
      end
    end
    assign pin_level[p] = stage_q[DEPTH-1];
    assign pin_edge[p]  = stage_q[DEPTH-1] ^ prev_q;
  end
endmodule

// File: rtl/change_latch.sv
module change_latch #(
  parameter int unsigned PINS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] edge_in,
  input  logic            rd_clr,
  output logic [PINS-1:0] chg_q,
  output logic            any_chg
);
  always_ff @(posedge clk) begin
    if (!rst_n) chg_q <= '0;
    else        chg_q <= (chg_q & {PINS{~rd_clr}}) | edge_in;
  end
  assign any_chg = |chg_q;
endmodule

// File: rtl/cond_status.sv
module cond_status #(
  parameter int unsigned SRCS = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SRCS-1:0] set_in,
  input  logic [SRCS-1:0] clr_in,
  output logic [SRCS-1:0] stat_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_in) | set_in;
  end
endmodule

// File: rtl/mask_gate.sv
module mask_gate #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] stat,
  output logic [WIDTH-1:0] mask_q,
  output logic             req_n
);
  always_ff @(posedge clk) begin
    if (!rst_n)  mask_q <= '0;
    else if (wr) mask_q <= wdata;
  end
  assign req_n = ~|(stat & mask_q);
endmodule

// File: rtl/intr_change_unit.sv
module intr_change_unit
  import intr_pkg::*;
#(
  parameter int unsigned SRCS  = SRC_COUNT,
  parameter int unsigned PINS  = PIN_COUNT,
  parameter int unsigned DEPTH = SYNC_DEPTH,
  localparam int unsigned SW   = SRCS + 1,
  localparam int unsigned CW   = 2 * PINS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SRCS-1:0] cond_set,
  input  logic [SRCS-1:0] cond_clr,
  input  logic [PINS-1:0] pins_in,
  input  logic            chg_rd,
  input  logic            mask_wr,
  input  logic [SW-1:0]   mask_wdata,
  output logic [SW-1:0]   mask_rdata,
  output logic [SW-1:0]   status,
  output logic [CW-1:0]   chg_rdata,
  output logic            irq_n
);
  logic [PINS-1:0] pin_level;
  logic [PINS-1:0] pin_edge;
  logic [PINS-1:0] chg_bits;
  logic            any_chg;
  logic [SRCS-1:0] src_stat;

  pin_change_det #(.PINS(PINS), .DEPTH(DEPTH)) u_det (
    .clk(clk), .rst_n(rst_n), .pin_raw(pins_in),
    .pin_level(pin_level), .pin_edge(pin_edge)
  );

  change_latch #(.PINS(PINS)) u_chg (
    .clk(clk), .rst_n(rst_n), .edge_in(pin_edge), .rd_clr(chg_rd),
    .chg_q(chg_bits), .any_chg(any_chg)
  );

  cond_status #(.SRCS(SRCS)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_in(cond_set), .clr_in(cond_clr),
    .stat_q(src_stat)
  );

  assign status    = {any_chg, src_stat};
  assign chg_rdata = {pin_level, chg_bits};

  mask_gate #(.WIDTH(SW)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr(mask_wr), .wdata(mask_wdata),
    .stat(status), .mask_q(mask_rdata), .req_n(irq_n)
  );
endmodule

// File: rtl/intr_change_chk.sv
module intr_change_chk #(
  parameter int unsigned SRCS = 7,
  parameter int unsigned PINS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [SRCS-1:0] cond_set,
  input logic [SRCS-1:0] cond_clr,
  input logic            chg_rd,
  input logic            mask_wr,
  input logic [SRCS:0]   mask_wdata,
  input logic [SRCS:0]   mask_rdata,
  input logic [SRCS:0]   status,
  input logic [PINS-1:0] chg_bits,
  input logic [PINS-1:0] pin_edge,
  input logic            irq_n
);
  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_set != '0) |=> ((status[SRCS-1:0] & $past(cond_set)) == $past(cond_set))); // R2
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((cond_clr & ~cond_set) != '0) |=> ((status[SRCS-1:0] & $past(cond_clr & ~cond_set)) == '0)); // R2
  AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && mask_wdata == '0) |=> irq_n); // R5
  AST_REQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (mask_rdata != '0)); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    chg_rd |=> ((chg_bits & ~$past(pin_edge)) == '0)); // R8
  AST_EDGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_edge != '0) |=> ((chg_bits & $past(pin_edge)) == $past(pin_edge))); // R9
endmodule

bind intr_change_unit intr_change_chk #(.SRCS(SRCS), .PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cond_set(cond_set), .cond_clr(cond_clr),
  .chg_rd(chg_rd), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
  .mask_rdata(mask_rdata), .status(status), .chg_bits(chg_bits),
  .pin_edge(pin_edge), .irq_n(irq_n)
);

// File: tb/tb_intr_change_unit.sv
module tb_intr_change_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // {set[6:0], clr[6:0], mask_wr, mask_data[7:0], exp_status[7:0], exp_irq_n}
  localparam logic [31:0] VEC [NV] = '{
    {7'h01, 7'h00, 1'b1, 8'hFF, 8'h01, 1'b0},
    {7'h00, 7'h01, 1'b0, 8'h00, 8'h00, 1'b1},
    {7'h22, 7'h00, 1'b1, 8'h02, 8'h22, 1'b0},
    {7'h00, 7'h00, 1'b1, 8'h20, 8'h22, 1'b0},
    {7'h00, 7'h00, 1'b1, 8'h00, 8'h22, 1'b1},
    {7'h08, 7'h08, 1'b0, 8'h00, 8'h2A, 1'b1},
    {7'h00, 7'h22, 1'b1, 8'hFF, 8'h08, 1'b0},
    {7'h00, 7'h08, 1'b0, 8'h00, 8'h00, 1'b1},
    {7'h7F, 7'h00, 1'b1, 8'h80, 8'h7F, 1'b1},
    {7'h00, 7'h7F, 1'b1, 8'h00, 8'h00, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] cond_set = '0;
  logic [6:0] cond_clr = '0;
  logic [3:0] pins_in = '0;
  logic       chg_rd = 1'b0;
  logic       mask_wr = 1'b0;
  logic [7:0] mask_wdata = '0;
  logic [7:0] mask_rdata;
  logic [7:0] status;
  logic [7:0] chg_rdata;
  logic       irq_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_change_unit dut (
    .clk(clk), .rst_n(rst_n), .cond_set(cond_set), .cond_clr(cond_clr),
    .pins_in(pins_in), .chg_rd(chg_rd), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .mask_rdata(mask_rdata), .status(status),
    .chg_rdata(chg_rdata), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) step();
    chk("R1 status", 32'(status), 32'h00);
    chk("R1 mask", 32'(mask_rdata), 32'h00);
    chk("R1 chg", 32'(chg_rdata), 32'h00);
    chk("R1 irq_n", 32'(irq_n), 32'h1);
    rst_n = 1'b1;
    step();

    // R2 R3 R4 R5: vector walk
    for (int i = 0; i < NV; i++) begin
      {cond_set, cond_clr, mask_wr, mask_wdata} = VEC[i][31:9];
      step();
      cond_set = '0; cond_clr = '0; mask_wr = 1'b0;
      chk($sformatf("R2/R3 status vec%0d", i), 32'(status), 32'(VEC[i][8:1]));
      chk($sformatf("R4/R5 irq_n vec%0d", i), 32'(irq_n), 32'(VEC[i][0]));
    end
    chk("R4 mask readback", 32'(mask_rdata), 32'h00);

    // R6 R7: pin 2 rises, only input change unmasked
    mask_wr = 1'b1; mask_wdata = 8'h80;
    step();
    mask_wr = 1'b0;
    pins_in = 4'b0100;
    step();
    chk("R6 level after one edge", 32'(chg_rdata), 32'h00);
    step();
    chk("R6 level after two edges", 32'(chg_rdata), 32'h40);
    chk("R7 no change bit yet", 32'(irq_n), 32'h1);
    step();
    chk("R7 change bit", 32'(chg_rdata), 32'h44);
    chk("R7 status bit7", 32'(status), 32'h80);
    chk("R7 irq_n", 32'(irq_n), 32'h0);

    // R8: read clears change bits, keeps level
    chg_rd = 1'b1;
    step();
    chg_rd = 1'b0;
    chk("R8 cleared", 32'(chg_rdata), 32'h40);
    chk("R8 status", 32'(status), 32'h00);
    chk("R8 irq_n", 32'(irq_n), 32'h1);

    // R9: pin 2 falls, read coincides with detection
    pins_in = 4'b0000;
    step();
    step();
    chg_rd = 1'b1;
    step();
    chg_rd = 1'b0;
    chk("R9 change kept", 32'(chg_rdata), 32'h04);
    chk("R9 irq_n", 32'(irq_n), 32'h0);
    chg_rd = 1'b1;
    step();
    chg_rd = 1'b0;
    chk("R8 second read", 32'(chg_rdata), 32'h00);

    // R1: reset mid-run clears status and mask
    cond_set = 7'h10; mask_wr = 1'b1; mask_wdata = 8'h10;
    step();
    cond_set = '0; mask_wr = 1'b0;
    chk("R2 pre-reset", 32'(status), 32'h10);
    rst_n = 1'b0;
    step();
    chk("R1 status reset", 32'(status), 32'h00);
    chk("R1 mask reset", 32'(mask_rdata), 32'h00);
    chk("R1 irq_n reset", 32'(irq_n), 32'h1);
    rst_n = 1'b1;
    step();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule